// File: doc/BRIEF.md
# PPS-Aligned Seconds/Ticks Time Keeper

This block maintains absolute time as a seconds count and a sub-second ticks count, both advancing on the master clock. The ticks count wraps once per second at a parameterised rate, and each wrap advances the seconds count. Software loads a new time through a small write-only register port. It first writes the seconds and ticks values it wants into shadow registers, then chooses when to apply them. The time is either applied at once or deferred until the next qualifying pulse-per-second edge.

Two pulse-per-second inputs exist. One comes from a front-panel connector and the other from a paired neighbouring device. A flag picks the source, and another flag picks the edge polarity. Both inputs pass through a two-flop synchronizer before edge detection. Every qualifying edge produces a one-cycle event output, which can serve as an interrupt source, whether or not a load is pending.

Top module: `pps_time_keeper`

## Requirements
- R1: While reset is asserted, seconds, ticks and the event output read 0.
- R2: Without a load, ticks rise by 1 every clock. When ticks equal TICKS_PER_SEC-1, the next clock sets ticks to 0 and adds 1 to seconds. Seconds wrap from all-ones to 0.
- R3: The register port decodes a 2-bit word address: 0 is the seconds value to load, 1 is the ticks value to load, 2 is the flags, and 3 is the arm/immediate register. Values written to addresses 0 and 1 are held unchanged until a load uses them and do not alter the running time.
- R4: A write to address 3 with data bit 0 = 1 loads the held seconds and ticks on that same clock edge, so they are read back in the following cycle. This write also cancels any pending deferred load.
- R5: A write to address 3 with data bit 0 = 0 arms a deferred load, which is applied on the next qualifying PPS edge. The armed state then clears, so later edges do not reload.
- R6: Flags bit 0 selects the qualifying edge: 0 = falling (reset value), 1 = rising. Edges of the other polarity produce no event and no load.
- R7: Flags bit 1 selects the PPS source: 0 = connector input (reset value), 1 = paired-device input. Transitions on the unselected input have no effect.
- R8: If a selected PPS input changes before clock edge E, the event output is high and any armed load is visible after edge E+2. The event output stays high for exactly one cycle.
- R9: A qualifying edge raises the event output even when no load is armed, and the time then continues counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register word address |
| wr_data | input | 32 | Register write data |
| pps_conn | input | 1 | PPS from connector, asynchronous |
| pps_peer | input | 1 | PPS from paired device, asynchronous |
| secs_o | output | SEC_W | Current seconds |
| ticks_o | output | TICK_W | Current ticks within the second |
| pps_evt_o | output | 1 | One-cycle qualifying-edge event |

## Verification
An immediate load is due one cycle after its write strobe, and plain counting moves one tick per cycle. The bench therefore drives every stimulus on a falling clock edge and predicts the time after n further edges with its own wrap model. A PPS transition needs three rising clock edges (two synchronizer stages and the edge flop) before the event and the deferred load appear. The bench checks that the event is still low after two edges, high after the third, and low again after the fourth. The bench uses a small TICKS_PER_SEC so that second and seconds-counter wraps occur within short runs.

// File: rtl/ptk_pkg.sv
package ptk_pkg;
  typedef enum logic [1:0] {
    REG_SECS  = 2'd0,
    REG_TICKS = 2'd1,
    REG_FLAGS = 2'd2,
    REG_ARM   = 2'd3
  } ptk_reg_e;

  typedef struct packed {
    logic src_peer;
    logic rise;
  } ptk_flags_t;
endpackage

// File: rtl/ptk_pps_edge.sv
module ptk_pps_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pps_i,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sync_q, sync_d;
  logic              last_q, last_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], pps_i};
    last_d = sync_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      last_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      last_q <= last_d;
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~last_q;
  assign fall_o = ~sync_q[STAGES-1] & last_q;
endmodule

// File: rtl/ptk_cfg.sv
module ptk_cfg
  import ptk_pkg::*;
#(
  parameter int SEC_W  = 32,
  parameter int TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              pps_hit,
  output logic [SEC_W-1:0]  sh_secs_o,
  output logic [TICK_W-1:0] sh_ticks_o,
  output ptk_flags_t        flags_o,
  output logic              load_now_o,
  output logic              pend_apply_o,
  output logic              pend_o
);
  logic [SEC_W-1:0]  secs_q, secs_d;
  logic [TICK_W-1:0] ticks_q, ticks_d;
  ptk_flags_t        flags_q, flags_d;
  logic              pend_q, pend_d;
  logic              arm_wr;

  assign arm_wr       = wr_en && (wr_addr == REG_ARM);
  assign load_now_o   = arm_wr && wr_data[0];
  assign pend_apply_o = pend_q && pps_hit;

  always_comb begin
    secs_d  = secs_q;
    ticks_d = ticks_q;
    flags_d = flags_q;
    pend_d  = pend_q;
    if (wr_en && (wr_addr == REG_SECS))  secs_d  = wr_data[SEC_W-1:0];
    if (wr_en && (wr_addr == REG_TICKS)) ticks_d = wr_data[TICK_W-1:0];
    if (wr_en && (wr_addr == REG_FLAGS)) flags_d = ptk_flags_t'(wr_data[1:0]);
    if (arm_wr)            pend_d = ~wr_data[0];
    else if (pend_apply_o) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      ticks_q <= '0;
      flags_q <= '0;
      pend_q  <= 1'b0;
    end else begin
      secs_q  <= secs_d;
      ticks_q <= ticks_d;
      flags_q <= flags_d;
      pend_q  <= pend_d;
    end
  end

  assign sh_secs_o  = secs_q;
  assign sh_ticks_o = ticks_q;
  assign flags_o    = flags_q;
  assign pend_o     = pend_q;
endmodule

// File: rtl/ptk_counter.sv
module ptk_counter #(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int SEC_W         = 32,
  parameter int TICK_W        = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [SEC_W-1:0]  ld_secs_i,
  input  logic [TICK_W-1:0] ld_ticks_i,
  output logic [SEC_W-1:0]  secs_o,
  output logic [TICK_W-1:0] ticks_o
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_SEC - 1);

  logic [SEC_W-1:0]  secs_q, secs_d;
  logic [TICK_W-1:0] ticks_q, ticks_d;

  always_comb begin
    if (load_i) begin
      secs_d  = ld_secs_i;
      ticks_d = ld_ticks_i;
    end else if (ticks_q == TICK_LAST) begin
      secs_d  = secs_q + SEC_W'(1);
      ticks_d = '0;
    end else begin
      secs_d  = secs_q;
      ticks_d = ticks_q + TICK_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q  <= '0;
      ticks_q <= '0;
    end else begin
      secs_q  <= secs_d;
      ticks_q <= ticks_d;
    end
  end

  assign secs_o  = secs_q;
  assign ticks_o = ticks_q;
endmodule

// File: rtl/pps_time_keeper.sv
module pps_time_keeper
  import ptk_pkg::*;
#(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int SEC_W         = 32,
  parameter int TICK_W        = 32,
  parameter int SYNC_STAGES   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [31:0]       wr_data,
  input  logic              pps_conn,
  input  logic              pps_peer,
  output logic [SEC_W-1:0]  secs_o,
  output logic [TICK_W-1:0] ticks_o,
  output logic              pps_evt_o
);
  localparam int NSRC = 2;

  logic [NSRC-1:0]   pps_raw, rise_v, fall_v;
  ptk_flags_t        flags;
  logic              pps_hit, load_now, pend_apply, pend_q, load_any;
  logic              evt_q, evt_d;
  logic [SEC_W-1:0]  sh_secs;
  logic [TICK_W-1:0] sh_ticks;

  assign pps_raw = {pps_peer, pps_conn};

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    ptk_pps_edge #(.STAGES(SYNC_STAGES)) edge_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .pps_i  (pps_raw[g]),
      .rise_o (rise_v[g]),
      .fall_o (fall_v[g])
    );
  end

  assign pps_hit = flags.rise ? rise_v[flags.src_peer] : fall_v[flags.src_peer];

  ptk_cfg #(.SEC_W(SEC_W), .TICK_W(TICK_W)) cfg_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pps_hit      (pps_hit),
    .sh_secs_o    (sh_secs),
    .sh_ticks_o   (sh_ticks),
    .flags_o      (flags),
    .load_now_o   (load_now),
    .pend_apply_o (pend_apply),
    .pend_o       (pend_q)
  );

  assign load_any = load_now | pend_apply;

  ptk_counter #(.TICKS_PER_SEC(TICKS_PER_SEC), .SEC_W(SEC_W), .TICK_W(TICK_W)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_any),
    .ld_secs_i  (sh_secs),
    .ld_ticks_i (sh_ticks),
    .secs_o     (secs_o),
    .ticks_o    (ticks_o)
  );

  assign evt_d = pps_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= 1'b0;
    else        evt_q <= evt_d;
  end

  assign pps_evt_o = evt_q;
endmodule

// File: rtl/ptk_checker.sv
module ptk_checker #(
  parameter int TICKS_PER_SEC = 100_000_000,
  parameter int SEC_W         = 32,
  parameter int TICK_W        = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              load_now,
  input logic              load_any,
  input logic              pend_q,
  input logic              pps_hit,
  input logic              arm_wr,
  input logic [SEC_W-1:0]  sh_secs,
  input logic [TICK_W-1:0] sh_ticks,
  input logic [SEC_W-1:0]  secs_o,
  input logic [TICK_W-1:0] ticks_o,
  input logic              pps_evt_o
);
  localparam logic [TICK_W-1:0] TICK_LAST = TICK_W'(TICKS_PER_SEC - 1);

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_any && ticks_o != TICK_LAST) |=> (ticks_o == $past(ticks_o) + TICK_W'(1)));

  // R2
  tick_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_any && ticks_o == TICK_LAST) |=> (ticks_o == '0 && secs_o == $past(secs_o) + SEC_W'(1)));

  // R4
  imm_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (secs_o == $past(sh_secs) && ticks_o == $past(sh_ticks)));

  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && pps_hit && !arm_wr) |=> !pend_q);

  // R8
  evt_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pps_evt_o |=> !pps_evt_o);
endmodule

bind pps_time_keeper ptk_checker #(
  .TICKS_PER_SEC(TICKS_PER_SEC), .SEC_W(SEC_W), .TICK_W(TICK_W)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .load_now  (load_now),
  .load_any  (load_any),
  .pend_q    (pend_q),
  .pps_hit   (pps_hit),
  .arm_wr    (wr_en && (wr_addr == 2'd3)),
  .sh_secs   (sh_secs),
  .sh_ticks  (sh_ticks),
  .secs_o    (secs_o),
  .ticks_o   (ticks_o),
  .pps_evt_o (pps_evt_o)
);

// File: tb/pps_time_keeper_tb_top.sv
module pps_time_keeper_tb_top;
  localparam int TPS = 20;
  localparam int NV  = 7;
  // fields: load secs, load ticks, extra cycles, expected secs, expected ticks
  localparam logic [31:0] VEC [NV][5] = '{
    '{32'd5,          32'd3,  32'd0,  32'd5,  32'd3},
    '{32'd5,          32'd3,  32'd4,  32'd5,  32'd7},
    '{32'd9,          32'd18, 32'd1,  32'd9,  32'd19},
    '{32'd9,          32'd19, 32'd1,  32'd10, 32'd0},
    '{32'd9,          32'd17, 32'd5,  32'd10, 32'd2},
    '{32'hFFFF_FFFF,  32'd19, 32'd1,  32'd0,  32'd0},
    '{32'd0,          32'd0,  32'd40, 32'd2,  32'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        pps_conn, pps_peer;
  logic [31:0] secs_o, ticks_o;
  logic        pps_evt_o;
  int          n_cmp = 0;
  int          n_bad = 0;
  logic [31:0] es, et;

  always #4 clk = ~clk;

  pps_time_keeper #(.TICKS_PER_SEC(TPS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pps_conn(pps_conn), .pps_peer(pps_peer),
    .secs_o(secs_o), .ticks_o(ticks_o), .pps_evt_o(pps_evt_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  function automatic void advance(inout logic [31:0] s, inout logic [31:0] t, input int n);
    for (int i = 0; i < n; i++) begin
      if (t == TPS - 1) begin t = 0; s = s + 1; end
      else t = t + 1;
    end
  endfunction

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    pps_conn = 1'b0; pps_peer = 1'b0;
    wait_n(3);
    chk("R1 secs", secs_o, 0);
    chk("R1 ticks", ticks_o, 0);
    chk("R1 evt", {31'd0, pps_evt_o}, 0);
    rst_n = 1'b1;
    wait_n(1);
    chk("R2 first tick", ticks_o, 1);

    // R4 / R2 table of immediate loads
    for (int v = 0; v < NV; v++) begin
      wr(2'd0, VEC[v][0]);
      wr(2'd1, VEC[v][1]);
      wr(2'd3, 32'd1);
      wait_n(int'(VEC[v][2]));
      chk("R4/R2 secs", secs_o, VEC[v][3]);
      chk("R4/R2 ticks", ticks_o, VEC[v][4]);
    end

    // R3: held seconds survive idle cycles before the ticks write
    wr(2'd0, 32'd77);
    wait_n(5);
    wr(2'd1, 32'd9);
    wr(2'd3, 32'd1);
    chk("R3 held secs", secs_o, 77);
    chk("R3 held ticks", ticks_o, 9);

    // R5/R6: armed load on falling edge of connector
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd100);
    wr(2'd1, 32'd4);
    wr(2'd3, 32'd0);
    es = secs_o; et = ticks_o;
    pps_conn = 1'b1;
    wait_n(3);
    advance(es, et, 3);
    chk("R6 rise ignored evt", {31'd0, pps_evt_o}, 0);
    chk("R6 rise ignored ticks", ticks_o, et);
    chk("R6 rise ignored secs", secs_o, es);
    pps_conn = 1'b0;
    wait_n(2);
    chk("R8 no evt at two edges", {31'd0, pps_evt_o}, 0);
    wait_n(1);
    chk("R8 evt at third edge", {31'd0, pps_evt_o}, 1);
    chk("R5 armed secs", secs_o, 100);
    chk("R5 armed ticks", ticks_o, 4);
    wait_n(1);
    chk("R8 evt one cycle", {31'd0, pps_evt_o}, 0);
    chk("R2 after load", ticks_o, 5);

    // R5/R9: second edge does not reload
    pps_conn = 1'b1;
    wait_n(3);
    pps_conn = 1'b0;
    wait_n(3);
    chk("R9 evt without arm", {31'd0, pps_evt_o}, 1);
    chk("R5 no reload secs", secs_o, 100);
    chk("R5 no reload ticks", ticks_o, 11);

    // R6/R7: peer source, rising edge
    wr(2'd2, 32'd3);
    wr(2'd0, 32'd7);
    wr(2'd1, 32'd0);
    wr(2'd3, 32'd0);
    es = secs_o; et = ticks_o;
    pps_conn = 1'b1;
    wait_n(3);
    advance(es, et, 3);
    chk("R7 connector ignored evt", {31'd0, pps_evt_o}, 0);
    chk("R7 connector ignored ticks", ticks_o, et);
    pps_peer = 1'b1;
    wait_n(3);
    chk("R7 peer rise evt", {31'd0, pps_evt_o}, 1);
    chk("R6 rise load secs", secs_o, 7);
    chk("R6 rise load ticks", ticks_o, 0);
    pps_peer = 1'b0;
    wait_n(3);
    chk("R6 fall ignored evt", {31'd0, pps_evt_o}, 0);
    chk("R6 fall ignored ticks", ticks_o, 3);

    // R4: immediate write cancels armed load
    pps_conn = 1'b0;
    wr(2'd2, 32'd0);
    wr(2'd0, 32'd55);
    wr(2'd1, 32'd2);
    wr(2'd3, 32'd0);
    wr(2'd3, 32'd1);
    chk("R4 cancel load secs", secs_o, 55);
    chk("R4 cancel load ticks", ticks_o, 2);
    pps_conn = 1'b1;
    wait_n(3);
    pps_conn = 1'b0;
    wait_n(3);
    chk("R4 cancel evt", {31'd0, pps_evt_o}, 1);
    chk("R4 cancel no reload ticks", ticks_o, 8);
    chk("R4 cancel no reload secs", secs_o, 55);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule